// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an asynchronous byte-wide static RAM with a 20-bit word address. The host issues one read or write at a time with a request/ready handshake. The sequencer turns each request into select, write-enable and read-enable strobes whose widths and gaps meet the memory's nanosecond minimums. Each minimum becomes a whole number of clock cycles, derived from a clock-period parameter given in picoseconds.

The memory has two chip selects of opposite polarity. The first is active low and the second is active high. It also has a single shared data bus. The sequencer models that bus as separate outgoing data, incoming data and drive-enable signals. After every read it waits for the memory outputs to float before it may drive the bus again. A sleep input parks the memory in its retention state. When sleep is released, ready stays low for one read-cycle time before the host may issue the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset the sequencer is idle: the first select, the second select, write-enable and read-enable are all high, drive-enable is low, and host_ready is high.
- R2: A read holds the first select low, the second select high, read-enable low and write-enable high. At the clock edge that ends the read it captures mem_dq_i, and it presents that byte on host_rdata with host_rvalid high for exactly one cycle.
- R3: A write holds the selects active and drives write-enable low. Drive-enable rises on the same edge and the write data is held on the bus for the whole pulse. Read-enable stays high throughout. The write pulse is at least 40 ns long, the data is stable at least 25 ns and the address at least 50 ns before write-enable rises. Write-enable, the selects and drive-enable are released together on one edge.
- R4: Drive-enable is high only while the chip is selected and write-enable is low.
- R5: After a read ends, drive-enable stays low for at least ceil(20 ns / clock period) clock edges.
- R6: host_ready is high only when the sequencer is idle and sleep is not requested. A request is taken only when host_req and host_ready are both high at a clock edge. host_ready is low in the cycle after a request is taken.
- R7: While sleep_req is high and no access is in progress, the first select is high, the second select is low and host_ready is low. Sleep takes priority over a pending request. A sleep request raised during an access takes effect after that access completes.
- R8: After sleep_req falls, host_ready stays low for at least ceil(55 ns / clock period) cycles.
- R9: A read strobe lasts max(ceil(55 ns/T), ceil(35 ns/T)) cycles and a write strobe lasts max(ceil(55/T), ceil(40/T), ceil(50/T), ceil(25/T)) cycles, where T is the clock period. Each term is at least 1.
- R10: mem_addr does not change while the chip is selected, and the driven write data does not change while drive-enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, taken when host_ready is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Sequencer can take a request |
| host_rdata | output | 8 | Read byte |
| host_rvalid | output | 1 | One-cycle pulse marking host_rdata valid |
| sleep_req | input | 1 | Request memory retention state |
| mem_addr | output | 20 | Memory address |
| mem_sel_n | output | 1 | First chip select, active low |
| mem_sel | output | 1 | Second chip select, active high |
| mem_wr_n | output | 1 | Write enable, active low |
| mem_rd_n | output | 1 | Read (output) enable, active low |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_i | input | 8 | Data from memory |
| mem_dq_drv | output | 1 | Controller drives the shared bus |

## Verification
The bench builds the sequencer with a 4000 ps clock period. This makes the read and write strobes 14 cycles long, the float gap 5 cycles and the recovery 14 cycles. With counts this long, a count that is one cycle short, a merged wrong term or a missing turnaround gap shows up as a measurable violation. The bench's memory model returns a garbage byte until 55 ns of read strobe have passed, so a read captured too early gives wrong data. Its write checker measures the pulse, data setup and address lead against nanosecond limits rather than cycle counts.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_SLEEP,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        logic sel_n;
        logic sel_p;
        logic wr_n;
        logic rd_n;
        logic drive;
    } pin_ctl_t;

    // whole cycles covering a time, never below one
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 32'd1) c = 32'd1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // pin levels held while the sequencer sits in a state
    function automatic pin_ctl_t pins_for(input seq_state_e st);
        pin_ctl_t p;
        p = '{sel_n: 1'b1, sel_p: 1'b1, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b0};
        case (st)
            ST_READ: begin
                p.sel_n = 1'b0;
                p.rd_n  = 1'b0;
            end
            ST_WRITE: begin
                p.sel_n = 1'b0;
                p.wr_n  = 1'b0;
                p.drive = 1'b1;
            end
            ST_SLEEP: p.sel_p = 1'b0;
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC  = 14,
    parameter int unsigned WR_CYC  = 14,
    parameter int unsigned HZ_CYC  = 5,
    parameter int unsigned REC_CYC = 14,
    parameter int unsigned CW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_write,
    input  logic          sleep_req,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          capture,
    output logic          ready,
    output pin_ctl_t      pins
);
    localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LD  = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] HZ_LD  = CW'(HZ_CYC - 1);
    localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);

    seq_state_e state_q, state_d;
    pin_ctl_t   pins_q;

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    state_d = ST_SLEEP;
                end else if (host_req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (host_write) begin
                        state_d  = ST_WRITE;
                        load_val = WR_LD;
                    end else begin
                        state_d  = ST_READ;
                        load_val = RD_LD;
                    end
                end
            end
            ST_READ: begin
                if (expired) begin
                    capture  = 1'b1;
                    state_d  = ST_TURN;
                    load     = 1'b1;
                    load_val = HZ_LD;
                end
            end
            ST_TURN, ST_WRITE, ST_RECOV: begin
                if (expired) state_d = ST_IDLE;
            end
            ST_SLEEP: begin
                if (!sleep_req) begin
                    state_d  = ST_RECOV;
                    load     = 1'b1;
                    load_val = REC_LD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ready = (state_q == ST_IDLE) && !sleep_req;

    // strobes come straight from flops so they never glitch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= pins_for(ST_IDLE);
        end else begin
            state_q <= state_d;
            pins_q  <= pins_for(state_d);
        end
    end

    assign pins = pins_q;

    p_drive_in_write_r4: assert property (@(posedge clk) disable iff (rst)
        pins.drive |-> (!pins.wr_n && !pins.sel_n && pins.sel_p));

    p_turn_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.drive) |-> $past(pins.rd_n));

    p_one_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

    p_sleep_standby_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP) |-> (pins.sel_n && !pins.sel_p && !ready));

    p_recover_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && !sleep_req) |=> !ready);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= dq_i;
        end
    end

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PS         = 4000,
    parameter int unsigned AW             = 20,
    parameter int unsigned DW             = 8,
    parameter int unsigned T_CYCLE_PS     = 55000,
    parameter int unsigned T_ADDR_ACC_PS  = 55000,
    parameter int unsigned T_RD_EN_ACC_PS = 35000,
    parameter int unsigned T_WPULSE_PS    = 40000,
    parameter int unsigned T_ADDR_END_PS  = 50000,
    parameter int unsigned T_DSETUP_PS    = 25000,
    parameter int unsigned T_FLOAT_PS     = 20000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_write,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    input  logic          sleep_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_wr_n,
    output logic          mem_rd_n,
    output logic [DW-1:0] mem_dq_o,
    input  logic [DW-1:0] mem_dq_i,
    output logic          mem_dq_drv
);
    localparam int unsigned RD_CYC = max_u(ps_to_cycles(T_CYCLE_PS, CLK_PS),
                                     max_u(ps_to_cycles(T_ADDR_ACC_PS, CLK_PS),
                                           ps_to_cycles(T_RD_EN_ACC_PS, CLK_PS)));
    localparam int unsigned WR_CYC = max_u(max_u(ps_to_cycles(T_CYCLE_PS, CLK_PS),
                                                 ps_to_cycles(T_WPULSE_PS, CLK_PS)),
                                           max_u(ps_to_cycles(T_ADDR_END_PS, CLK_PS),
                                                 ps_to_cycles(T_DSETUP_PS, CLK_PS)));
    localparam int unsigned HZ_CYC  = ps_to_cycles(T_FLOAT_PS, CLK_PS);
    localparam int unsigned REC_CYC = ps_to_cycles(T_CYCLE_PS, CLK_PS);
    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WR_CYC), max_u(HZ_CYC, REC_CYC));
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic          load, expired, accept, capture;
    logic [CW-1:0] load_val;
    pin_ctl_t      pins;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    sram_cycle_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .RD_CYC  (RD_CYC),
        .WR_CYC  (WR_CYC),
        .HZ_CYC  (HZ_CYC),
        .REC_CYC (REC_CYC),
        .CW      (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_write (host_write),
        .sleep_req  (sleep_req),
        .expired    (expired),
        .load       (load),
        .load_val   (load_val),
        .accept     (accept),
        .capture    (capture),
        .ready      (host_ready),
        .pins       (pins)
    );

    sram_rd_capture #(.DW(DW)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .dq_i    (mem_dq_i),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

    // address and data are taken on the same edge the strobes start
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_o   = wdata_q;
    assign mem_sel_n  = pins.sel_n;
    assign mem_sel    = pins.sel_p;
    assign mem_wr_n   = pins.wr_n;
    assign mem_rd_n   = pins.rd_n;
    assign mem_dq_drv = pins.drive;

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    p_wdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_drv && $past(mem_dq_drv)) |-> $stable(mem_dq_o));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
    localparam int CLK_PS = 4000;

    function automatic int cyc(input int ps);
        int c;
        c = (ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_RD  = mx(cyc(55000), cyc(35000));
    localparam int EXP_WR  = mx(mx(cyc(55000), cyc(40000)), mx(cyc(50000), cyc(25000)));
    localparam int EXP_REC = cyc(55000);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_write = 1'b0, sleep_req = 1'b0;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;
    logic [19:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_drv;
    logic [7:0]  mem_dq_o, mem_dq_i;

    always #2 clk = ~clk;

    sram_async_ctrl #(.CLK_PS(CLK_PS)) i_sram_async_ctrl (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_write(host_write), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .sleep_req(sleep_req),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_dq_o(mem_dq_o),
        .mem_dq_i(mem_dq_i), .mem_dq_drv(mem_dq_drv)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory with timing checks ----------------
    logic [7:0] dev_mem [logic [19:0]];
    logic [7:0] ref_mem [logic [19:0]];
    wire rd_mode = !mem_sel_n && mem_sel && mem_wr_n && !mem_rd_n;
    wire wr_mode = !mem_sel_n && mem_sel && !mem_wr_n;
    int rd_age, wr_age, d_age, addr_age, hz_age;
    bit addr_moved;
    logic [19:0] prev_addr, wr_addr;
    logic [7:0]  wr_data;

    function automatic logic [7:0] dev_read(input logic [19:0] a);
        return dev_mem.exists(a) ? dev_mem[a] : 8'h00;
    endfunction

    // garbage until both access times have passed
    assign mem_dq_i = (rd_mode && rd_age * CLK_PS >= 55000 && rd_age * CLK_PS >= 35000)
                      ? dev_read(mem_addr) : 8'hEE;

    always @(negedge clk) begin
        if (rst) begin
            rd_age = 0; wr_age = 0; d_age = 0; addr_age = 0; hz_age = 99;
            addr_moved = 1'b0; prev_addr = mem_addr;
        end else begin
            if (mem_dq_drv) begin
                if (!wr_mode) chk(1'b0, "R4 drive outside write", 1, 0);
                if (hz_age * CLK_PS < 20000) chk(1'b0, "R5 drive before float gap", hz_age, cyc(20000));
            end
            if (wr_mode && !mem_rd_n) chk(1'b0, "R3 read enable low in write", 0, 1);
            if (!rd_mode && rd_age != 0) begin
                chk(rd_age == EXP_RD, "R9 read strobe length", rd_age, EXP_RD);
                chk(!addr_moved, "R10 address moved in read", 1, 0);
                rd_age = 0; addr_moved = 1'b0;
            end
            if (!wr_mode && wr_age != 0) begin
                chk(wr_age * CLK_PS >= 40000, "R3 write pulse width", wr_age, cyc(40000));
                chk(d_age * CLK_PS >= 25000, "R3 data setup", d_age, cyc(25000));
                chk(addr_age * CLK_PS >= 50000, "R3 address lead", addr_age, cyc(50000));
                chk(wr_age == EXP_WR, "R9 write strobe length", wr_age, EXP_WR);
                chk(!mem_dq_drv && mem_sel_n, "R3 release together", mem_dq_drv, 0);
                chk(!addr_moved, "R10 address moved in write", 1, 0);
                dev_mem[wr_addr] = wr_data;
                wr_age = 0; addr_moved = 1'b0;
            end
            if (rd_mode) begin
                rd_age++;
                hz_age = 0;
            end else if (hz_age < 99) begin
                hz_age++;
            end
            if (wr_mode) begin
                wr_age++;
                wr_addr = mem_addr;
                if (mem_dq_drv && wr_age > 1 && mem_dq_o == wr_data) d_age++;
                else if (mem_dq_drv) d_age = 1;
                else d_age = 0;
                wr_data = mem_dq_o;
            end
            if ((rd_age > 1 || wr_age > 1) && mem_addr != prev_addr) addr_moved = 1'b1;
            if (mem_addr != prev_addr) addr_age = 1;
            else addr_age++;
            prev_addr = mem_addr;
        end
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q[$];
    logic [7:0] exp_b;
    bit prev_valid = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (host_rvalid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected read data", int'(host_rdata), 0);
                end else begin
                    exp_b = exp_q.pop_front();
                    chk(host_rdata == exp_b, "R2 read data", int'(host_rdata), int'(exp_b));
                end
                chk(!prev_valid, "R2 valid is a single cycle", 1, 0);
            end
            prev_valid = host_rvalid;
        end
    end

    task automatic host_op(input bit wr, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        if (wr) ref_mem[a] = d;
        else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'h00);
        @(negedge clk);
        host_req = 1'b0;
        chk(!host_ready, "R6 ready drops after accept", host_ready, 0);
    endtask

    task automatic drain();
        int n = 0;
        while ((!host_ready || exp_q.size() != 0) && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_sleep_pins(input string tag);
        chk(mem_sel_n == 1'b1 && mem_sel == 1'b0, tag, {mem_sel_n, mem_sel}, 2);
        chk(!host_ready, "R7 ready low in sleep", host_ready, 0);
    endtask

    task automatic release_sleep();
        int low = 0;
        sleep_req = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (host_ready) break;
            low++;
        end
        chk(low >= EXP_REC, "R8 recovery before ready", low, EXP_REC);
        chk(mem_sel_n && mem_sel, "R8 selects back to idle", {mem_sel_n, mem_sel}, 3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(mem_sel_n && mem_sel && mem_wr_n && mem_rd_n && !mem_dq_drv,
            "R1 pins during reset", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_drv}, 5'b11110);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ready, "R1 ready after reset", host_ready, 1);
        chk(mem_sel_n && mem_sel && mem_wr_n && mem_rd_n && !mem_dq_drv,
            "R1 pins after reset", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_drv}, 5'b11110);

        // varied patterns, both address ends
        host_op(1'b1, 20'h00000, 8'h5A);
        host_op(1'b1, 20'hFFFFF, 8'hA5);
        host_op(1'b1, 20'h12345, 8'h3C);
        host_op(1'b1, 20'hAAAAA, 8'hC3);
        host_op(1'b0, 20'h00000, 8'h00);
        host_op(1'b0, 20'hFFFFF, 8'h00);
        host_op(1'b0, 20'h00100, 8'h00);   // never written: zero
        host_op(1'b1, 20'h55555, 8'h01);   // write right after read: turnaround R5
        host_op(1'b0, 20'h55555, 8'h00);   // read right after write
        host_op(1'b1, 20'h12345, 8'h7E);   // overwrite
        host_op(1'b0, 20'h12345, 8'h00);
        host_op(1'b0, 20'hAAAAA, 8'h00);
        drain();

        // R7: sleep while idle
        sleep_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_sleep_pins("R7 sleep selects idle");
        release_sleep();
        host_op(1'b0, 20'hFFFFF, 8'h00);
        drain();

        // R7: sleep beats a pending request
        @(negedge clk);
        sleep_req = 1'b1; host_req = 1'b1; host_write = 1'b0; host_addr = 20'h00000;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check_sleep_pins("R7 sleep over pending request");
            chk(!host_rvalid, "R7 no access while sleeping", host_rvalid, 0);
        end
        host_req = 1'b0;
        release_sleep();

        // R7: sleep raised mid-write waits for the write to finish
        host_op(1'b1, 20'h0F0F0, 8'h99);
        sleep_req = 1'b1;
        chk(!mem_wr_n, "R7 write continues after sleep raised", mem_wr_n, 0);
        repeat (EXP_WR + 3) @(negedge clk);
        check_sleep_pins("R7 sleep after write");
        release_sleep();
        host_op(1'b0, 20'h0F0F0, 8'h00);
        host_op(1'b0, 20'h00000, 8'h00);
        drain();
        chk(exp_q.size() == 0, "R2 every read returned", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule